// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off state of every switch in a square crosspoint fabric of eight rows by eight columns. A write selects one cell with a row address and a column address, presents a data bit and raises a strobe. While the strobe stays high the chosen cell tracks the data bit. When the strobe drops, the cell keeps the last value it was given. No other cell is affected by the write.

A master clear input turns every switch off at once. It acts without waiting for a clock edge and it overrides any strobe activity. All control inputs are registered on the block clock. The stored state appears in three forms: a flat vector of all cells, a column-by-row grid of the same bits, and a single bit picked by a separate readback index. The row and column address widths are parameters. A second parameter chooses the structure of the address decoder.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: The cell index is {col_addr, row_addr}, so the column address forms the upper bits. Cell (column c, row r) appears at sw_state[c*8+r] and at sw_grid[c][r].
- R2: Strobing a 1 into a cell turns it on and strobing a 0 turns it off. Inputs presented before clock edge k show up on sw_state after edge k+1.
- R3: While strobe stays high, the addressed cell takes on the data bit of each cycle. Each value appears with the same two-edge delay, so toggling the data toggles the switch.
- R4: After strobe returns low, the addressed cell holds the data bit from the last strobed cycle.
- R5: A write changes only the addressed cell. All other cells keep their value.
- R6: While rst is high, all cells read 0. The clear takes effect without waiting for a clock edge.
- R7: A strobe asserted while rst is high writes nothing. Every cell still reads 0 after rst is released, until a new strobe is applied.
- R8: After reset every output reads 0. Any combination of cells may then be on at the same time, with no exclusivity by row or column.
- R9: rd_bit equals the stored bit of the cell whose index is rd_idx, and it follows rd_idx without a clock edge.
- R10: sw_grid always carries the same bits as sw_state, arranged by column and then by row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Master clear, active high, asynchronous |
| row_addr | input | ROW_AW (3) | Row select of the cell to write |
| col_addr | input | COL_AW (3) | Column select of the cell to write |
| wr_data | input | 1 | Value to store: 1 turns the switch on, 0 turns it off |
| strobe | input | 1 | Write enable, active high |
| rd_idx | input | ROW_AW+COL_AW (6) | Index of the cell to read back |
| sw_state | output | 64 | All switch states, bit c*8+r for column c and row r |
| sw_grid | output | 8x8 | The same states as [column][row] |
| rd_bit | output | 1 | Stored state of cell rd_idx |

## Verification
sw_state and sw_grid change two clock edges after the inputs are presented: one edge to register the inputs and one to update the cell. The driver therefore tags every expected vector with the cycle count two edges ahead. The monitor compares that vector at the falling edge of exactly that cycle, when the outputs have settled. rd_bit and the reset clear have no clock delay, so they are checked a short delay after rd_idx or rst changes, within the same half-cycle. For these checks the bench first lets all pending writes drain, so the reference model matches the stored cells.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

   // Structure of the write-enable decoder.
   typedef enum logic [0:0] {
      DEC_FLAT  = 1'b0,   // one full-index comparator per cell
      DEC_SPLIT = 1'b1    // row one-hot AND column one-hot
   } dec_style_e;

   localparam int unsigned MAX_AW = 4;  // upper bound for each address width

endpackage

// File: rtl/xpt_in_stage.sv
module xpt_in_stage #(
   parameter int unsigned ROW_AW = 3,
   parameter int unsigned COL_AW = 3
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [ROW_AW-1:0]        row_addr,
   input  logic [COL_AW-1:0]        col_addr,
   input  logic                     wr_data,
   input  logic                     strobe,
   output logic [ROW_AW+COL_AW-1:0] idx_q,
   output logic                     dat_q,
   output logic                     stb_q
);

   // Registers all write controls. The column address forms the upper index bits.
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         idx_q <= '0;
         dat_q <= 1'b0;
         stb_q <= 1'b0;
      end else begin
         idx_q <= {col_addr, row_addr};
         dat_q <= wr_data;
         stb_q <= strobe;
      end
   end

endmodule

// File: rtl/xpt_dec.sv
module xpt_dec #(
   parameter int unsigned         ROW_AW    = 3,
   parameter int unsigned         COL_AW    = 3,
   parameter xpt_pkg::dec_style_e DEC_STYLE = xpt_pkg::DEC_SPLIT
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic [ROW_AW+COL_AW-1:0]             idx_q,
   input  logic                                 stb_q,
   output logic [(1<<(ROW_AW+COL_AW))-1:0]      wr_en
);

   localparam int unsigned N_ROWS  = 1 << ROW_AW;
   localparam int unsigned N_COLS  = 1 << COL_AW;
   localparam int unsigned CELL_AW = ROW_AW + COL_AW;
   localparam int unsigned N_CELLS = 1 << CELL_AW;

   generate
      if (DEC_STYLE == xpt_pkg::DEC_FLAT) begin : g_flat
         for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
            assign wr_en[i] = stb_q && (idx_q == CELL_AW'(i));
         end
      end else begin : g_split
         logic [ROW_AW-1:0] row_sel;
         logic [COL_AW-1:0] col_sel;
         logic [N_ROWS-1:0] row_oh;
         logic [N_COLS-1:0] col_oh;

         assign row_sel = idx_q[ROW_AW-1:0];
         assign col_sel = idx_q[CELL_AW-1:ROW_AW];

         for (genvar r = 0; r < N_ROWS; r++) begin : g_row
            assign row_oh[r] = (row_sel == ROW_AW'(r));
         end
         for (genvar c = 0; c < N_COLS; c++) begin : g_col
            assign col_oh[c] = stb_q && (col_sel == COL_AW'(c));
         end
         for (genvar c = 0; c < N_COLS; c++) begin : g_and_c
            for (genvar r = 0; r < N_ROWS; r++) begin : g_and_r
               assign wr_en[c*N_ROWS + r] = col_oh[c] & row_oh[r];
            end
         end
      end
   endgenerate

   // R5: at most one cell is enabled on any edge.
   a_r5_single_enable: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_en));

endmodule

// File: rtl/xpt_cells.sv
module xpt_cells #(
   parameter int unsigned N_CELLS = 64
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_CELLS-1:0] wr_en,
   input  logic               dat_q,
   output logic [N_CELLS-1:0] cell_q
);

   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               cell_q[i] <= 1'b0;
            end else if (wr_en[i]) begin
               cell_q[i] <= dat_q;
            end
         end

         // R3: an enabled cell takes on the registered data.
         a_r3_follow: assert property (@(posedge clk) disable iff (rst)
            wr_en[i] |=> (cell_q[i] == $past(dat_q)));

         // R5: a cell that is not enabled keeps its value.
         a_r5_keep: assert property (@(posedge clk) disable iff (rst)
            !wr_en[i] |=> $stable(cell_q[i]));
      end
   endgenerate

endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
   parameter int unsigned         ROW_AW    = 3,
   parameter int unsigned         COL_AW    = 3,
   parameter xpt_pkg::dec_style_e DEC_STYLE = xpt_pkg::DEC_SPLIT
) (
   input  logic                                        clk,
   input  logic                                        rst,
   input  logic [ROW_AW-1:0]                           row_addr,
   input  logic [COL_AW-1:0]                           col_addr,
   input  logic                                        wr_data,
   input  logic                                        strobe,
   input  logic [ROW_AW+COL_AW-1:0]                    rd_idx,
   output logic [(1<<(ROW_AW+COL_AW))-1:0]             sw_state,
   output logic [(1<<COL_AW)-1:0][(1<<ROW_AW)-1:0]     sw_grid,
   output logic                                        rd_bit
);

   localparam int unsigned N_ROWS  = 1 << ROW_AW;
   localparam int unsigned N_COLS  = 1 << COL_AW;
   localparam int unsigned CELL_AW = ROW_AW + COL_AW;
   localparam int unsigned N_CELLS = 1 << CELL_AW;

   generate
      if (ROW_AW < 1 || ROW_AW > xpt_pkg::MAX_AW) begin : g_bad_row
         $error("xpt_ctrl_mem: ROW_AW out of range");
      end
      if (COL_AW < 1 || COL_AW > xpt_pkg::MAX_AW) begin : g_bad_col
         $error("xpt_ctrl_mem: COL_AW out of range");
      end
   endgenerate

   logic [CELL_AW-1:0] idx_q;
   logic               dat_q;
   logic               stb_q;
   logic [N_CELLS-1:0] wr_en;
   logic [N_CELLS-1:0] cell_q;

   xpt_in_stage #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) in_i (
      .clk(clk), .rst(rst), .row_addr(row_addr), .col_addr(col_addr),
      .wr_data(wr_data), .strobe(strobe),
      .idx_q(idx_q), .dat_q(dat_q), .stb_q(stb_q)
   );

   xpt_dec #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .DEC_STYLE(DEC_STYLE)) dec_i (
      .clk(clk), .rst(rst), .idx_q(idx_q), .stb_q(stb_q), .wr_en(wr_en)
   );

   xpt_cells #(.N_CELLS(N_CELLS)) cells_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .dat_q(dat_q), .cell_q(cell_q)
   );

   assign sw_state = cell_q;
   assign rd_bit   = cell_q[rd_idx];

   generate
      for (genvar c = 0; c < N_COLS; c++) begin : g_gc
         for (genvar r = 0; r < N_ROWS; r++) begin : g_gr
            assign sw_grid[c][r] = cell_q[c*N_ROWS + r];
         end
      end
   endgenerate

   // R6: every switch reads off while the clear is held.
   a_r6_clear: assert property (@(posedge clk) rst |-> (sw_state == '0));

   // R7: the first edge after the clear leaves all cells off.
   a_r7_no_write_in_reset: assert property (@(posedge clk)
      $fell(rst) |-> (sw_state == '0));

endmodule

// File: tb/xpt_ctrl_mem_tb_top.sv
module xpt_ctrl_mem_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] row_addr = '0;
   logic [2:0] col_addr = '0;
   logic       wr_data = 1'b0;
   logic       strobe = 1'b0;
   logic [5:0] rd_idx = '0;
   logic [63:0]         sw_state;
   logic [7:0][7:0]     sw_grid;
   logic                rd_bit;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [63:0] model = '0;

   typedef struct {
      int          due;
      logic [63:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];

   xpt_ctrl_mem dut_i (
      .clk(clk), .rst(rst), .row_addr(row_addr), .col_addr(col_addr),
      .wr_data(wr_data), .strobe(strobe), .rd_idx(rd_idx),
      .sw_state(sw_state), .sw_grid(sw_grid), .rd_bit(rd_bit)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check_vec(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Monitor: compares each due item at the falling edge of its cycle (R10 grid too).
   always @(negedge clk) begin
      if (!rst) begin
         while (sbq.size() > 0 && sbq[0].due == cyc) begin
            item_t it;
            logic [63:0] flat;
            it = sbq.pop_front();
            check_vec(it.tag, sw_state, it.exp);
            for (int c = 0; c < 8; c++)
               for (int r = 0; r < 8; r++)
                  flat[c*8+r] = sw_grid[c][r];
            check_vec("R10 grid", flat, sw_state);
         end
      end
   end

   // Driver: applies one cycle of inputs at a falling edge, result due two edges on.
   task automatic step(input bit s, input int c, input int r, input bit d, input string tag);
      strobe   = s;
      col_addr = 3'(c);
      row_addr = 3'(r);
      wr_data  = d;
      if (s) model[c*8+r] = d;
      sbq.push_back('{cyc + 2, model, tag});
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) step(1'b0, 0, 0, 1'b0, tag);
   endtask

   task automatic wr(input int c, input int r, input bit d, input string tag);
      step(1'b1, c, r, d, tag);
      idle(1, tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_vec("R8 reset state", sw_state, 64'h0);
      checks++;
      if (rd_bit !== 1'b0) begin
         errors++;
         $display("FAIL R8 rd_bit: actual %b expected 0", rd_bit);
      end
      rst = 1'b0;
      idle(2, "R8 idle after reset");

      // R1/R2: corners and an interior cell (column 3, row 5 is bit 29).
      wr(0, 0, 1'b1, "R1 R2 col0 row0 on");
      wr(7, 7, 1'b1, "R1 col7 row7 on");
      wr(3, 5, 1'b1, "R1 col3 row5 bit29");
      wr(0, 7, 1'b1, "R1 col0 row7 bit7");
      wr(0, 0, 1'b0, "R2 col0 row0 off");
      idle(3, "R5 others hold");

      // R3: data toggles under a held strobe, R4: last strobed value kept.
      step(1'b1, 2, 1, 1'b1, "R3 follow");
      step(1'b1, 2, 1, 1'b0, "R3 follow");
      step(1'b1, 2, 1, 1'b1, "R3 follow");
      step(1'b1, 2, 1, 1'b0, "R3 follow");
      idle(4, "R4 hold 0");
      step(1'b1, 6, 4, 1'b0, "R3 follow");
      step(1'b1, 6, 4, 1'b1, "R3 follow");
      idle(4, "R4 hold 1");

      // R8/R5: a full column and a full row at once, no exclusivity.
      for (int r = 0; r < 8; r++) wr(4, r, 1'b1, "R8 column 4 all on");
      for (int c = 0; c < 8; c++) wr(c, 2, 1'b1, "R8 row 2 all on");
      wr(4, 3, 1'b0, "R5 single cell off");
      idle(3, "R5 drain");

      // R9: readback of every cell against the model.
      for (int i = 0; i < 64; i++) begin
         rd_idx = 6'(i);
         #1;
         checks++;
         if (rd_bit !== model[i]) begin
            errors++;
            $display("FAIL R9 idx %0d: actual %b expected %b", i, rd_bit, model[i]);
         end
      end

      // R6/R7: clear while a strobe writes a 1.
      strobe = 1'b1; col_addr = 3'd5; row_addr = 3'd5; wr_data = 1'b1;
      @(negedge clk);
      #1 rst = 1'b1;
      #0.5 check_vec("R6 async clear", sw_state, 64'h0);
      repeat (3) begin
         @(negedge clk);
         check_vec("R7 strobe ignored in reset", sw_state, 64'h0);
      end
      strobe = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      model = '0;
      sbq.delete();
      idle(3, "R7 zero after release");
      wr(1, 6, 1'b1, "R2 write after reset");
      idle(3, "R5 drain");
      rd_idx = 6'd14;
      #1;
      checks++;
      if (rd_bit !== 1'b1) begin
         errors++;
         $display("FAIL R9 idx 14: actual %b expected 1", rd_bit);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule